// File: doc/BRIEF.md
# Virtqueue Doorbell Decoder

This block sits on the write side of a register bus and turns driver writes into doorbell events for individual virtqueues. Each queue owns a small notify-offset index. The block turns that index into a byte address by multiplying it by a region-wide spacing multiplier and adding the fixed start of the notification window. The driver rings a queue by writing the queue's number as a 16-bit value to that queue's address. One clock later the block raises that queue's bit on `ring_o` for exactly one cycle.

The multiplier is an input, so software-visible capability values can drive it. Only zero, or a power of two of at least 2, is legal. Because of this, each scaled offset is a left shift rather than a product. A multiplier of zero collapses every queue onto the window start. The written value then decides which queue rings. Any other multiplier is flagged as illegal, and the whole decoder falls silent. Writes are also dropped when the written number does not name a configured queue, when the address is not that queue's doorbell, or when the doorbell would lie past the end of the window.

Top module: `dbell_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, `ring_o` is all zeros.
- R2: With a legal non-zero multiplier M, a write to address BASE_OFF + qoff[q]*M carrying value q sets bit q of `ring_o`, and only that bit, in the cycle after the write, for exactly one cycle. Writes in consecutive cycles give pulses in consecutive cycles.
- R3: With M = 0, every queue's doorbell is BASE_OFF. A write there carrying value q rings queue q.
- R4: `mult_bad_o` is 1 when M is 1, odd, or has more than one bit set, and 0 for zero or for a single set bit at position 1 or above. While it is 1, no write produces a pulse.
- R5: A written value at or above NUM_QUEUES produces no pulse, even at a queue's doorbell address. All 16 data bits are compared.
- R6: A write whose address is not the doorbell of the queue named by its value produces no pulse. This includes another queue's doorbell.
- R7: A queue whose doorbell address is at or beyond BASE_OFF + REGION_LEN can never be rung.
- R8: At most one bit of `ring_o` is set in any cycle. No pulse appears without a write enable in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W | Byte address of the write |
| wr_data_i | input | 16 | Written queue number |
| mult_i | input | MULT_W | Doorbell spacing multiplier in bytes |
| qoff_i | input | NUM_QUEUES*QOFF_W | Per-queue notify-offset indices; queue q at bits [q*QOFF_W +: QOFF_W] |
| ring_o | output | NUM_QUEUES | One-cycle doorbell pulse per queue |
| mult_bad_o | output | 1 | Multiplier is not a legal value |

## Verification
The bench builds the decoder with its defaults: eight queues, 20-bit addresses, 8-bit offset indices, a 16-bit multiplier, a window at 0x3000 and a window length of 4096 bytes. It gives the highest queue an offset index of 200. A multiplier of 4 then keeps every doorbell inside the window, while a multiplier of 32 pushes the last queue past the end, which brings R7 within reach. A 16-bit multiplier allows the largest legal value, 0x8000, and several illegal odd and multi-bit values to be applied. Eight queues leave room for indices from 8 up to values with high bits set.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    localparam int unsigned DATA_W  = 16;
    localparam int unsigned SHIFT_W = 6;

    typedef enum logic [1:0] {
        MODE_SPREAD  = 2'd0,
        MODE_SHARED  = 2'd1,
        MODE_ILLEGAL = 2'd2
    } mult_mode_e;

    typedef struct packed {
        mult_mode_e         mode;
        logic [SHIFT_W-1:0] shift;
    } mult_cfg_t;

    // Legal spacing: zero, or one set bit at position 1 or above.
    function automatic logic mult_is_legal(input logic [31:0] m);
        return (m == 32'd0) || ((m[0] == 1'b0) && $onehot(m));
    endfunction

    // Position of the highest set bit; only meaningful for one-hot input.
    function automatic logic [SHIFT_W-1:0] mult_log2(input logic [31:0] m);
        logic [SHIFT_W-1:0] sh;
        sh = '0;
        for (int i = 0; i < 32; i++) begin
            if (m[i]) sh = SHIFT_W'(i);
        end
        return sh;
    endfunction

endpackage

// File: rtl/dbell_mult_check.sv
module dbell_mult_check
    import dbell_pkg::*;
#(
    parameter int unsigned MULT_W = 16
) (
    input  logic [MULT_W-1:0] mult_i,
    output mult_cfg_t         cfg_o
);

    logic [31:0] m32;

    always_comb begin
        m32         = 32'(mult_i);
        cfg_o.shift = mult_log2(m32);
        if (!mult_is_legal(m32)) begin
            cfg_o.mode = MODE_ILLEGAL;
        end else if (m32 == 32'd0) begin
            cfg_o.mode = MODE_SHARED;
        end else begin
            cfg_o.mode = MODE_SPREAD;
        end
    end

endmodule

// File: rtl/dbell_addr_gen.sv
module dbell_addr_gen
    import dbell_pkg::*;
#(
    parameter int unsigned       NUM_QUEUES = 8,
    parameter int unsigned       ADDR_W     = 20,
    parameter int unsigned       QOFF_W     = 8,
    parameter int unsigned       MULT_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_OFF   = 20'h03000,
    parameter int unsigned       REGION_LEN = 4096
) (
    input  logic [NUM_QUEUES*QOFF_W-1:0] qoff_i,
    input  mult_cfg_t                    cfg_i,
    output logic [NUM_QUEUES*ADDR_W-1:0] qaddr_o,
    output logic [NUM_QUEUES-1:0]        qvalid_o
);

    localparam int unsigned WIDE_W = ADDR_W + QOFF_W + MULT_W;
    localparam logic [WIDE_W-1:0] BASE_W  = WIDE_W'(BASE_OFF);
    localparam logic [WIDE_W-1:0] LIMIT_W = WIDE_W'(BASE_OFF) + WIDE_W'(REGION_LEN);

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
        logic [WIDE_W-1:0] scaled;
        logic [WIDE_W-1:0] full;

        always_comb begin
            if (cfg_i.mode == MODE_SHARED) begin
                scaled = '0;
            end else begin
                scaled = WIDE_W'(qoff_i[q*QOFF_W +: QOFF_W]) << cfg_i.shift;
            end
            full = BASE_W + scaled;
        end

        assign qaddr_o[q*ADDR_W +: ADDR_W] = full[ADDR_W-1:0];
        assign qvalid_o[q] = (cfg_i.mode != MODE_ILLEGAL) && (full < LIMIT_W);
    end

endmodule

// File: rtl/dbell_match.sv
module dbell_match
    import dbell_pkg::*;
#(
    parameter int unsigned NUM_QUEUES = 8,
    parameter int unsigned ADDR_W     = 20
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [DATA_W-1:0]            wr_data_i,
    input  logic [NUM_QUEUES*ADDR_W-1:0] qaddr_i,
    input  logic [NUM_QUEUES-1:0]        qvalid_i,
    output logic [NUM_QUEUES-1:0]        ring_o
);

    localparam logic [DATA_W-1:0] QCOUNT = DATA_W'(NUM_QUEUES);

    logic                  idx_ok;
    logic [NUM_QUEUES-1:0] hit;

    assign idx_ok = wr_data_i < QCOUNT;

    for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_hit
        assign hit[q] = wr_en_i && idx_ok && qvalid_i[q]
                     && (wr_data_i == DATA_W'(q))
                     && (wr_addr_i == qaddr_i[q*ADDR_W +: ADDR_W]);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ring_o <= '0;
        end else begin
            ring_o <= hit;
        end
    end

endmodule

// File: rtl/dbell_decoder.sv
module dbell_decoder
    import dbell_pkg::*;
#(
    parameter int unsigned       NUM_QUEUES = 8,
    parameter int unsigned       ADDR_W     = 20,
    parameter int unsigned       QOFF_W     = 8,
    parameter int unsigned       MULT_W     = 16,
    parameter logic [ADDR_W-1:0] BASE_OFF   = 20'h03000,
    parameter int unsigned       REGION_LEN = 4096
) (
    input  logic                         clk_i,
    input  logic                         rst_i,
    input  logic                         wr_en_i,
    input  logic [ADDR_W-1:0]            wr_addr_i,
    input  logic [15:0]                  wr_data_i,
    input  logic [MULT_W-1:0]            mult_i,
    input  logic [NUM_QUEUES*QOFF_W-1:0] qoff_i,
    output logic [NUM_QUEUES-1:0]        ring_o,
    output logic                         mult_bad_o
);

    mult_cfg_t                    cfg;
    logic [NUM_QUEUES*ADDR_W-1:0] qaddr;
    logic [NUM_QUEUES-1:0]        qvalid;

    dbell_mult_check #(
        .MULT_W (MULT_W)
    ) u_mult (
        .mult_i (mult_i),
        .cfg_o  (cfg)
    );

    dbell_addr_gen #(
        .NUM_QUEUES (NUM_QUEUES),
        .ADDR_W     (ADDR_W),
        .QOFF_W     (QOFF_W),
        .MULT_W     (MULT_W),
        .BASE_OFF   (BASE_OFF),
        .REGION_LEN (REGION_LEN)
    ) u_addr (
        .qoff_i   (qoff_i),
        .cfg_i    (cfg),
        .qaddr_o  (qaddr),
        .qvalid_o (qvalid)
    );

    dbell_match #(
        .NUM_QUEUES (NUM_QUEUES),
        .ADDR_W     (ADDR_W)
    ) u_match (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .qaddr_i   (qaddr),
        .qvalid_i  (qvalid),
        .ring_o    (ring_o)
    );

    assign mult_bad_o = (cfg.mode == MODE_ILLEGAL);

endmodule

// File: rtl/dbell_decoder_chk.sv
module dbell_decoder_chk #(
    parameter int unsigned NUM_QUEUES = 8,
    parameter int unsigned MULT_W     = 16
) (
    input logic                  clk_i,
    input logic                  rst_i,
    input logic                  wr_en_i,
    input logic [15:0]           wr_data_i,
    input logic [MULT_W-1:0]     mult_i,
    input logic [NUM_QUEUES-1:0] ring_o,
    input logic                  mult_bad_o
);

    AST_RING_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(ring_o));  // R8

    AST_RING_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
        (ring_o != '0) |-> $past(wr_en_i));  // R8

    AST_RING_MATCHES_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
        (ring_o != '0) |-> (ring_o == (NUM_QUEUES'(1) << $past(wr_data_i))));  // R2

    AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (ring_o != '0) |-> ($past(wr_data_i) < 16'(NUM_QUEUES)));  // R5

    AST_BAD_MULT_SILENT: assert property (@(posedge clk_i) disable iff (rst_i)
        (ring_o != '0) |-> !$past(mult_bad_o));  // R4

    AST_MULT_ONE_BAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (mult_i == MULT_W'(1)) |-> mult_bad_o);  // R4

endmodule

bind dbell_decoder dbell_decoder_chk #(
    .NUM_QUEUES (NUM_QUEUES),
    .MULT_W     (MULT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .mult_i     (mult_i),
    .ring_o     (ring_o),
    .mult_bad_o (mult_bad_o)
);

// File: tb/dbell_decoder_tb.sv
module dbell_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NQ    = 8;
    localparam int AW    = 20;
    localparam int QW    = 8;
    localparam int MW    = 16;
    localparam int BASE  = 'h3000;
    localparam int RLEN  = 4096;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 wr_en = 1'b0;
    logic [AW-1:0]        wr_addr = '0;
    logic [15:0]          wr_data = '0;
    logic [MW-1:0]        mult = 16'd4;
    logic [NQ*QW-1:0]     qoff = {8'd200, 8'd9, 8'd7, 8'd5, 8'd3, 8'd2, 8'd1, 8'd0};
    logic [NQ-1:0]        ring;
    logic                 mult_bad;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbell_decoder u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .mult_i     (mult),
        .qoff_i     (qoff),
        .ring_o     (ring),
        .mult_bad_o (mult_bad)
    );

    function automatic logic [AW-1:0] door(input int q, input int m);
        return AW'(BASE + int'(qoff[q*QW +: QW]) * m);
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One write; checks the pulse cycle and the cycle after it.
    task automatic poke(input logic [AW-1:0] a, input logic [15:0] d, input logic en,
                        input int exp_q, input string tag);
        logic [NQ-1:0] e;
        e = (exp_q < 0) ? '0 : (NQ'(1) << exp_q);
        @(negedge clk);
        wr_en = en; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(32'(ring), 32'(e), tag);
        @(negedge clk);
        check(32'(ring), 0, {tag, " single-cycle"});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(32'(ring), 0, "R1 ring in reset");
        rst = 1'b0;
        @(negedge clk);
        check(32'(ring), 0, "R1 ring after reset");
        check(32'(mult_bad), 0, "R4 mult 4 legal");
    endtask

    task automatic t_spread;
        mult = 16'd4;
        for (int q = 0; q < NQ; q++) poke(door(q, 4), 16'(q), 1'b1, q, "R2 spread m=4");
        mult = 16'd2;
        poke(door(5, 2), 16'd5, 1'b1, 5, "R2 spread m=2");
        // back-to-back writes
        mult = 16'd4;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = door(1, 4); wr_data = 16'd1;
        @(negedge clk);
        wr_addr = door(2, 4); wr_data = 16'd2;
        check(32'(ring), 32'h02, "R2 back-to-back first");
        @(negedge clk);
        wr_en = 1'b0;
        check(32'(ring), 32'h04, "R2 back-to-back second");
        @(negedge clk);
        check(32'(ring), 0, "R2 back-to-back idle");
    endtask

    task automatic t_shared;
        mult = 16'd0;
        @(negedge clk);
        check(32'(mult_bad), 0, "R4 mult 0 legal");
        poke(AW'(BASE), 16'd0, 1'b1, 0, "R3 shared q0");
        poke(AW'(BASE), 16'd3, 1'b1, 3, "R3 shared q3");
        poke(AW'(BASE), 16'd7, 1'b1, 7, "R3 shared q7");
        poke(AW'(BASE + 4), 16'd1, 1'b1, -1, "R3 shared off-base");
    endtask

    task automatic t_bad_mult;
        mult = 16'd1;
        @(negedge clk);
        check(32'(mult_bad), 1, "R4 mult 1 flagged");
        poke(door(2, 1), 16'd2, 1'b1, -1, "R4 mult 1 silent");
        mult = 16'd6;
        @(negedge clk);
        check(32'(mult_bad), 1, "R4 mult 6 flagged");
        poke(door(1, 6), 16'd1, 1'b1, -1, "R4 mult 6 silent");
        poke(AW'(BASE), 16'd0, 1'b1, -1, "R4 mult 6 q0 silent");
        mult = 16'd3;
        @(negedge clk);
        check(32'(mult_bad), 1, "R4 mult 3 flagged");
        mult = 16'h8000;
        @(negedge clk);
        check(32'(mult_bad), 0, "R4 mult 8000 legal");
    endtask

    task automatic t_bad_index;
        mult = 16'd4;
        poke(AW'(BASE), 16'd8, 1'b1, -1, "R5 index 8");
        poke(AW'(BASE), 16'h0100, 1'b1, -1, "R5 index high bits");
        poke(door(1, 4), 16'h8001, 1'b1, -1, "R5 index top bit");
    endtask

    task automatic t_mismatch;
        mult = 16'd4;
        poke(door(2, 4), 16'd1, 1'b1, -1, "R6 other queue address");
        poke(door(0, 4) + 2, 16'd0, 1'b1, -1, "R6 off by two");
        poke(door(3, 4) + 1, 16'd3, 1'b1, -1, "R6 off by one");
    endtask

    task automatic t_region;
        mult = 16'd32;
        poke(door(7, 32), 16'd7, 1'b1, -1, "R7 beyond window");
        poke(door(6, 32), 16'd6, 1'b1, 6, "R7 inside window");
    endtask

    task automatic t_no_enable;
        mult = 16'd4;
        poke(door(4, 4), 16'd4, 1'b0, -1, "R8 no strobe");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_spread();
        t_shared();
        t_bad_mult();
        t_bad_index();
        t_mismatch();
        t_region();
        t_no_enable();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule